// File: doc/BRIEF.md
# Dual-Task Register Programming Sequencer

This block runs two independent command lists that program a bank of control registers without help from the host. Each task has its own program counter and a small set of configuration inputs: a start address, a page that forms the upper bits of every memory address the task uses, and a wait-timeout count. A task is started by a one-cycle pulse on its start input. It then fetches 32-bit command words from memory in order and executes them. The commands load a register, copy a register into memory, wait for a condition, jump (with or without a condition), change the shared signal flags, and stop.

The two tasks share one memory port and one register port. Both ports use a request/acknowledge handshake. A round-robin arbiter decides which task uses each port. Five shared signal flags are visible on an output. Either task can set or clear them, and both wait commands and conditional jumps can test them. This lets the two tasks hand work to each other and report progress to the host. A wait that lasts too long ends its task and raises a timeout flag.

Top module: `dual_task_seq`

## Requirements
- R1: After reset, both enable outputs, both done pulses, both timeout flags, all five signal flags and both port requests are 0.
- R2: A pulse on `task_go[t]` while task t is idle starts the task. Its first fetch is from memory address {page, start address}. A start pulse that arrives while the task is running has no effect on the running program.
- R3: Opcode 1 in bits 31:28 means load register. It writes the word that follows the command to the register whose index is in bits 3:0. This is exactly one register-port write.
- R4: Opcode 2 means upload. It reads the register whose index is in bits 3:0. It then writes that value to memory address {page, bits 23:16}.
- R5: Opcode 3 means wait. Bits 12:0 are a mask over the condition vector. Events occupy bits 7:0 of that vector and signal flags occupy bits 12:8. The task stalls until every masked bit is 1.
- R6: During a wait, a counter loaded from `task_tmo` counts down. If it runs out, the task stops and `task_tmo_flag` is set. A stop by timeout gives no done pulse. The next start clears the flag.
- R7: Opcode 4 jumps to the address in bits 23:16 if every bit set in mask bits 12:0 is 1 in the condition vector. Otherwise the task continues with the next word.
- R8: Opcode 5 sets the flags given in bits 4:0 and clears the flags given in bits 12:8. When a flag is both set and cleared, the set wins. The flags change only at the end of such a fetch.
- R9: Opcode 6 always jumps to the address in bits 23:16. Opcodes 7 to 15 are skipped with no effect.
- R10: Opcode 0 stops the task. The enable output drops and `task_done[t]` is 1 for exactly one cycle.
- R11: When both tasks wait for the same port, the port alternates between them. The task that was served last loses the tie.
- R12: Once a port request is raised, the request, its address and its direction stay unchanged until the acknowledge arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| task_go | input | 2 | Start pulse per task |
| task_addr | input | 2x8 | Program start address per task |
| task_page | input | 2x4 | Memory page per task |
| task_tmo | input | 2x16 | Wait timeout count per task |
| task_en | output | 2 | Task running |
| task_done | output | 2 | One-cycle pulse when a task stops on opcode 0 |
| task_tmo_flag | output | 2 | Task ended by wait timeout |
| events | input | 8 | Event inputs tested by wait and jump |
| sig | output | 5 | Shared signal flags |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | 12 | Memory word address {page, offset} |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory acknowledge |
| mem_rdata | input | 32 | Memory read data, valid with acknowledge |
| reg_req | output | 1 | Register request |
| reg_we | output | 1 | Register write (1) or read (0) |
| reg_addr | output | 4 | Register index |
| reg_wdata | output | 32 | Register write data |
| reg_ack | input | 1 | Register acknowledge |
| reg_rdata | input | 32 | Register read data, valid with acknowledge |

## Verification
The bench makes one task wait on a flag that only the other task sets. A design that tested the wrong condition bit, or released the wait too early, would write the guarded register before the event arrives. Jump tests take one taken branch and one not-taken branch, then reach an undefined opcode. A design with a reversed mask test or a mis-decoded opcode would produce a different register-write sequence, and the scoreboard would reject it. A wait with a short timeout must end its task without a done pulse. A start pulse sent during a wait must not restart the program. A free-running sequence from both tasks must fetch from alternating pages, which a fixed-priority arbiter would fail.

// File: rtl/dual_task_seq.sv
module dual_task_seq #(
  parameter int AW = 8,
  parameter int PW = 4,
  parameter int RW = 4,
  parameter int TW = 16,
  parameter int EW = 8,
  parameter int NS = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          task_go,
  input  logic [1:0][AW-1:0]  task_addr,
  input  logic [1:0][PW-1:0]  task_page,
  input  logic [1:0][TW-1:0]  task_tmo,
  output logic [1:0]          task_en,
  output logic [1:0]          task_done,
  output logic [1:0]          task_tmo_flag,
  input  logic [EW-1:0]       events,
  output logic [NS-1:0]       sig,
  output logic                mem_req,
  output logic                mem_we,
  output logic [PW+AW-1:0]    mem_addr,
  output logic [31:0]         mem_wdata,
  input  logic                mem_ack,
  input  logic [31:0]         mem_rdata,
  output logic                reg_req,
  output logic                reg_we,
  output logic [RW-1:0]       reg_addr,
  output logic [31:0]         reg_wdata,
  input  logic                reg_ack,
  input  logic [31:0]         reg_rdata
);
  localparam int CW = NS + EW;

  typedef enum logic [2:0] {IDLE, FETCH, DATA, REGW, REGR, MEMW, WAIT} st_t;

  st_t             st   [2];
  logic [AW-1:0]   pc   [2];
  logic [AW-1:0]   ctgt [2];
  logic [CW-1:0]   cmask[2];
  logic [31:0]     dat  [2];
  logic [TW-1:0]   cnt  [2];

  logic [1:0] mwant, rwant, mdone, rdone, met;
  logic [1:0][NS-1:0] sset, sclr;
  logic mbusy, mid, mlast, rbusy, rid, rlast;

  wire [CW-1:0] cond  = {sig, events};
  wire          fmet  = (cond & mem_rdata[CW-1:0]) == mem_rdata[CW-1:0];
  wire          mpick = (&mwant) ? ~mlast : mwant[1];
  wire          rpick = (&rwant) ? ~rlast : rwant[1];

  for (genvar t = 0; t < 2; t++) begin : g_task
    assign task_en[t] = st[t] != IDLE;
    assign mwant[t]   = st[t] inside {FETCH, DATA, MEMW};
    assign rwant[t]   = st[t] inside {REGW, REGR};
    assign mdone[t]   = mem_ack && mbusy && mid == 1'(t);
    assign rdone[t]   = reg_ack && rbusy && rid == 1'(t);
    assign met[t]     = (cond & cmask[t]) == cmask[t];
    assign sset[t]    = (st[t] == FETCH && mdone[t] && mem_rdata[31:28] == 4'd5) ? mem_rdata[NS-1:0] : '0;
    assign sclr[t]    = (st[t] == FETCH && mdone[t] && mem_rdata[31:28] == 4'd5) ? mem_rdata[8 +: NS] : '0;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mbusy <= 1'b0; mid <= 1'b0; mlast <= 1'b1;
      rbusy <= 1'b0; rid <= 1'b0; rlast <= 1'b1;
    end else begin
      if (mbusy) begin
        if (mem_ack) mbusy <= 1'b0;
      end else if (|mwant) begin
        mbusy <= 1'b1; mid <= mpick; mlast <= mpick;
      end
      if (rbusy) begin
        if (reg_ack) rbusy <= 1'b0;
      end else if (|rwant) begin
        rbusy <= 1'b1; rid <= rpick; rlast <= rpick;
      end
    end

  assign mem_req   = mbusy;
  assign mem_we    = st[mid] == MEMW;
  assign mem_addr  = {task_page[mid], (st[mid] == MEMW) ? ctgt[mid] : pc[mid]};
  assign mem_wdata = dat[mid];
  assign reg_req   = rbusy;
  assign reg_we    = st[rid] == REGW;
  assign reg_addr  = cmask[rid][RW-1:0];
  assign reg_wdata = dat[rid];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sig <= '0;
    else        sig <= (sig & ~(sclr[0] | sclr[1])) | sset[0] | sset[1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int t = 0; t < 2; t++) begin
        st[t] <= IDLE; pc[t] <= '0; ctgt[t] <= '0; cmask[t] <= '0;
        dat[t] <= '0; cnt[t] <= '0;
      end
      task_done     <= '0;
      task_tmo_flag <= '0;
    end else begin
      task_done <= '0;
      for (int t = 0; t < 2; t++) begin
        case (st[t])
          IDLE: if (task_go[t]) begin
            st[t] <= FETCH; pc[t] <= task_addr[t]; task_tmo_flag[t] <= 1'b0;
          end
          FETCH: if (mdone[t]) begin
            ctgt[t]  <= mem_rdata[16 +: AW];
            cmask[t] <= mem_rdata[CW-1:0];
            pc[t]    <= pc[t] + 1'b1;
            case (mem_rdata[31:28])
              4'd0: begin st[t] <= IDLE; task_done[t] <= 1'b1; end
              4'd1: st[t] <= DATA;
              4'd2: st[t] <= REGR;
              4'd3: begin st[t] <= WAIT; cnt[t] <= task_tmo[t]; end
              4'd4: if (fmet) pc[t] <= mem_rdata[16 +: AW];
              4'd6: pc[t] <= mem_rdata[16 +: AW];
              default: ;
            endcase
          end
          DATA: if (mdone[t]) begin
            dat[t] <= mem_rdata; pc[t] <= pc[t] + 1'b1; st[t] <= REGW;
          end
          REGW: if (rdone[t]) st[t] <= FETCH;
          REGR: if (rdone[t]) begin dat[t] <= reg_rdata; st[t] <= MEMW; end
          MEMW: if (mdone[t]) st[t] <= FETCH;
          WAIT:
            if (met[t]) st[t] <= FETCH;
            else if (cnt[t] == '0) begin st[t] <= IDLE; task_tmo_flag[t] <= 1'b1; end
            else cnt[t] <= cnt[t] - 1'b1;
          default: st[t] <= IDLE;
        endcase
      end
    end

  // R12
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));
  // R12
  reg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_req && !reg_ack |=> reg_req && $stable(reg_addr) && $stable(reg_we));
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    |task_done |=> (task_done & $past(task_done)) == 2'b00);
  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (task_done & task_en) == 2'b00);
  // R6
  tmo_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (task_tmo_flag & task_en) == 2'b00);
  // R8
  sig_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_ack |=> $stable(sig));
endmodule

// File: tb/dual_task_seq_tb.sv
`timescale 1ns/1ps
module dual_task_seq_tb;
  logic clk = 0, rst_n = 0;
  logic [1:0] task_go = 0;
  logic [1:0][7:0] task_addr = '0;
  logic [1:0][3:0] task_page = '0;
  logic [1:0][15:0] task_tmo = '0;
  logic [1:0] task_en, task_done, task_tmo_flag;
  logic [7:0] events = 0;
  logic [4:0] sig;
  logic mem_req, mem_we, mem_ack = 0, reg_req, reg_we, reg_ack = 0;
  logic [11:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata = 0, reg_wdata, reg_rdata = 0;
  logic [3:0] reg_addr;

  dual_task_seq u_dut (.clk(clk), .rst_n(rst_n), .task_go(task_go), .task_addr(task_addr),
    .task_page(task_page), .task_tmo(task_tmo), .task_en(task_en), .task_done(task_done),
    .task_tmo_flag(task_tmo_flag), .events(events), .sig(sig), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_ack(reg_ack), .reg_rdata(reg_rdata));

  always #2.5 clk = ~clk;

  logic [31:0] mem [0:4095];
  logic [31:0] regs [0:15];
  logic [35:0] exp_q [$];
  logic [11:0] flog [$];
  bit log_on = 0;
  int n_chk = 0, n_fail = 0, done0 = 0, done1 = 0, hold_bad = 0;
  bit finished = 0;

  task automatic check(string req, logic [31:0] act, logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  function automatic logic [31:0] c_load(logic [3:0] r); return {4'h1, 24'h0, r}; endfunction
  function automatic logic [31:0] c_up(logic [3:0] r, logic [7:0] a); return {4'h2, 4'h0, a, 12'h0, r}; endfunction
  function automatic logic [31:0] c_wait(logic [12:0] m); return {4'h3, 15'h0, m}; endfunction
  function automatic logic [31:0] c_jif(logic [12:0] m, logic [7:0] a); return {4'h4, 4'h0, a, 3'h0, m}; endfunction
  function automatic logic [31:0] c_sig(logic [4:0] s, logic [4:0] c); return {4'h5, 15'h0, c, 3'h0, s}; endfunction
  function automatic logic [31:0] c_jmp(logic [7:0] a); return {4'h6, 4'h0, a, 16'h0}; endfunction

  task automatic expect_wr(logic [3:0] a, logic [31:0] d); exp_q.push_back({a, d}); endtask

  task automatic go(logic [1:0] m);
    @(negedge clk); task_go = m;
    @(negedge clk); task_go = 0;
  endtask

  task automatic wait_idle(logic [1:0] m);
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      if ((task_en & m) == 0) break;
    end
  endtask

  // memory responder
  initial forever begin
    @(posedge clk);
    if (mem_req && !mem_ack) begin
      if (mem_we) mem[mem_addr] = mem_wdata;
      mem_rdata <= mem[mem_addr];
      mem_ack <= 1;
    end else mem_ack <= 0;
  end

  // register responder
  initial forever begin
    @(posedge clk);
    if (reg_req && !reg_ack) begin
      if (reg_we) regs[reg_addr] = reg_wdata;
      reg_rdata <= regs[reg_addr];
      reg_ack <= 1;
    end else reg_ack <= 0;
  end

  // monitor: scoreboard of register writes, fetch log, done pulses, request hold
  initial begin
    logic pm_req, pm_ack, pm_we, pr_req, pr_ack, pr_we;
    logic [11:0] pm_addr; logic [3:0] pr_addr;
    pm_req = 0; pm_ack = 0; pr_req = 0; pr_ack = 0;
    pm_we = 0; pr_we = 0; pm_addr = 0; pr_addr = 0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (reg_req && reg_ack && reg_we) begin
          if (exp_q.size() == 0) check("R3 unexpected register write", {28'h0, reg_addr}, 32'hFFFF_FFFF);
          else begin
            logic [35:0] e;
            e = exp_q.pop_front();
            check("R3 write index", {28'h0, reg_addr}, {28'h0, e[35:32]});
            check("R3 write data", reg_wdata, e[31:0]);
          end
        end
        if (log_on && mem_req && mem_ack && !mem_we) flog.push_back(mem_addr);
        if (task_done[0]) done0++;
        if (task_done[1]) done1++;
        if (pm_req && !pm_ack && (!mem_req || mem_addr != pm_addr || mem_we != pm_we)) hold_bad++;
        if (pr_req && !pr_ack && (!reg_req || reg_addr != pr_addr || reg_we != pr_we)) hold_bad++;
      end
      pm_req = mem_req; pm_ack = mem_ack; pm_addr = mem_addr; pm_we = mem_we;
      pr_req = reg_req; pr_ack = reg_ack; pr_addr = reg_addr; pr_we = reg_we;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 0;
    for (int i = 0; i < 16; i++) regs[i] = 0;
    regs[5] = 32'h1234_5678;
    // task 0 programs, page 0
    mem[12'h010] = c_load(3); mem[12'h011] = 32'hA5A5_0001;
    mem[12'h012] = c_sig(5'b00001, 0); mem[12'h013] = 0;
    mem[12'h030] = c_wait(13'h200); mem[12'h031] = c_load(2); mem[12'h032] = 32'h77; mem[12'h033] = 0;
    mem[12'h060] = c_jif(13'h100, 8'h68); mem[12'h061] = c_load(7); mem[12'h062] = 1;
    mem[12'h063] = c_jif(13'h1000, 8'h6C); mem[12'h064] = c_load(8); mem[12'h065] = 3;
    mem[12'h066] = 32'h9000_0000; mem[12'h067] = 0;
    mem[12'h068] = c_load(7); mem[12'h069] = 2; mem[12'h06A] = c_jmp(8'h63);
    mem[12'h070] = c_sig(5'b10000, 5'b00011); mem[12'h071] = c_sig(5'b00100, 5'b00100); mem[12'h072] = 0;
    for (int i = 0; i < 6; i++) begin mem[12'h0A0 + i] = c_sig(0, 0); mem[12'h1A0 + i] = c_sig(0, 0); end
    mem[12'h0A6] = 0; mem[12'h1A6] = 0;
    // task 1 programs, page 1
    mem[12'h120] = c_up(5, 8'h40); mem[12'h121] = 0;
    mem[12'h150] = c_wait(13'h004); mem[12'h151] = c_sig(5'b00010, 0); mem[12'h152] = 0;
    mem[12'h180] = c_wait(13'h080); mem[12'h181] = c_load(9); mem[12'h182] = 32'h99; mem[12'h183] = 0;
    mem[12'h190] = 0;

    task_page[0] = 0; task_page[1] = 1;
    task_tmo[0] = 1000; task_tmo[1] = 1000;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 enable", {30'h0, task_en}, 0);
    check("R1 done", {30'h0, task_done}, 0);
    check("R1 timeout flag", {30'h0, task_tmo_flag}, 0);
    check("R1 signals", {27'h0, sig}, 0);
    check("R1 requests", {30'h0, mem_req, reg_req}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R2, R3, R8, R10: load, set flag, stop
    task_addr[0] = 8'h10;
    expect_wr(3, 32'hA5A5_0001);
    flog.delete(); log_on = 1;
    go(2'b01);
    check("R2 running after start", {31'h0, task_en[0]}, 1);
    wait_idle(2'b01);
    log_on = 0;
    check("R2 first fetch address", {20'h0, flog[0]}, 32'h010);
    check("R3 register 3", regs[3], 32'hA5A5_0001);
    check("R8 flag 0 set", {27'h0, sig}, 32'h01);
    check("R10 enable cleared", {31'h0, task_en[0]}, 0);
    check("R10 one done pulse", done0, 1);

    // R4 upload
    task_addr[1] = 8'h20;
    go(2'b10);
    wait_idle(2'b10);
    check("R4 memory copy", mem[12'h140], 32'h1234_5678);
    check("R10 task1 done", done1, 1);

    // R5 cross-task wait
    task_addr[0] = 8'h30; task_addr[1] = 8'h50;
    expect_wr(2, 32'h77);
    go(2'b11);
    repeat (40) @(negedge clk);
    check("R5 both still waiting", {30'h0, task_en}, 3);
    check("R5 guarded register untouched", regs[2], 0);
    events[2] = 1;
    wait_idle(2'b11);
    events[2] = 0;
    check("R5 register written after release", regs[2], 32'h77);
    check("R5 flag 1 set by task1", {31'h0, sig[1]}, 1);

    // R7, R9 jumps and skipped opcode
    task_addr[0] = 8'h60;
    expect_wr(7, 2); expect_wr(8, 3);
    go(2'b01);
    wait_idle(2'b01);
    check("R7 taken branch", regs[7], 2);
    check("R7 not-taken branch", regs[8], 3);
    check("R9 skip opcode then stop", done0, 3);

    // R8 clear and set-wins
    task_addr[0] = 8'h70;
    go(2'b01);
    wait_idle(2'b01);
    check("R8 clear and set-wins", {27'h0, sig}, 32'h14);

    // R6 timeout
    task_addr[1] = 8'h80; task_tmo[1] = 3;
    go(2'b10);
    wait_idle(2'b10);
    check("R6 timeout flag", {31'h0, task_tmo_flag[1]}, 1);
    check("R6 no done pulse", done1, 2);
    check("R6 no load after timeout", regs[9], 0);

    // R6 flag cleared on start, R2 start ignored while running
    task_tmo[1] = 200;
    expect_wr(9, 32'h99);
    go(2'b10);
    check("R6 flag cleared by start", {31'h0, task_tmo_flag[1]}, 0);
    repeat (10) @(negedge clk);
    task_addr[1] = 8'h90;
    go(2'b10);
    repeat (10) @(negedge clk);
    events[7] = 1;
    wait_idle(2'b10);
    events[7] = 0;
    check("R2 restart ignored", regs[9], 32'h99);
    check("R6 no timeout when event arrives", {31'h0, task_tmo_flag[1]}, 0);

    // R11 round-robin
    task_addr[0] = 8'hA0; task_addr[1] = 8'hA0;
    flog.delete(); log_on = 1;
    go(2'b11);
    wait_idle(2'b11);
    log_on = 0;
    check("R11 fetch count", {31'h0, flog.size() >= 8}, 1);
    for (int i = 0; i < 7; i++)
      if (i + 1 < flog.size())
        check("R11 alternating page", {31'h0, flog[i][8] != flog[i+1][8]}, 1);

    check("R12 requests held until acknowledge", hold_bad, 0);
    check("R3 all expected writes seen", exp_q.size(), 0);
    summary();
  end
endmodule